// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter Pair

This block holds two 16-bit timer/counters. Each is built from a low byte and a high byte and is set up by a 4-bit field in a shared mode byte: a gate-qualify bit, a source-select bit and a 2-bit operating mode. A run bit and an overflow flag for each unit sit in a control byte. The control byte also holds a cascade bit, which joins the two units into one 32-bit counter. The count source is either an internal tick or a falling edge on a synchronized external count pin. The internal tick is a one-cycle pulse that comes once every `TICK_DIV` clock cycles, twelve by default. A gate pin for each unit can qualify counting.

Software reaches the six bytes through a small synchronous bus: a write strobe with a 3-bit address and a data byte, and a read port that decodes the address combinationally. Each flag is driven out as an overflow request. The flag stays set until a one-cycle acknowledge pulse for that unit clears it, or until software rewrites it.

The flow of each cycle is named as follows. In `TICK_WAIT` the prescaler counts toward its terminal value, and in `TICK_FIRE` it emits the tick. Each external pin passes through a synchronizer into a two-state level tracker, `LV_LOW` and `LV_HIGH`. The `LV_HIGH -> LV_LOW` transition is the only one that produces a count. The `LV_LOW -> LV_HIGH` transition and the self-loops produce none. For each unit, the mode decode then selects one of `MD_PRE13`, `MD_FULL16`, `MD_RELOAD8` or `MD_SPLIT`. The cascade path overrides all of them.

Top module: `tc_pair`

## Requirements
- R1: After reset, all four counter bytes, the mode byte, the control byte and both overflow outputs are zero.
- R2: The bus map is: address 0 is the unit 0 low byte, 1 the unit 0 high byte, 2 the unit 1 low byte, 3 the unit 1 high byte, 4 the mode byte and 5 the control byte. Mode byte bits [3:0] configure unit 0 and bits [7:4] configure unit 1. Within each nibble, bit 3 is gate, bit 2 is external source and bits 1:0 are the mode. In the control byte, bit 0 is run0, bit 1 is run1, bit 2 is flag0, bit 3 is flag1 and bit 4 is cascade. Control bits 7:5 read as zero.
- R3: Mode 01 counts the high and low bytes as one 16-bit value. A wrap from FFFF to 0000 sets that unit's flag.
- R4: Mode 00 counts a 13-bit value made of the high byte above the low byte's bits 4:0, and leaves low-byte bits 7:5 unchanged. A 13-bit wrap sets the unit's flag.
- R5: Mode 10 counts the low byte only. On a count at FF, the low byte loads the high byte's value and the flag is set. The high byte is unchanged.
- R6: Unit 0 in mode 11 splits into two 8-bit counters. The low byte counts under unit 0's own run, gate and source, and its carry sets flag0. The high byte counts the internal tick whenever run1 is 1, and its carry sets flag1.
- R7: Unit 1 in mode 11 holds both of its bytes, whatever the run bit and the pin activity.
- R8: With gate 0, counting follows the run bit alone. With gate 1, counting also requires the unit's gate pin to be high.
- R9: With source 0, a running unit advances exactly once per `TICK_DIV` cycles. With source 1, it advances once per high-to-low transition of its count pin.
- R10: With cascade set, {hi1,lo1,hi0,lo0} counts as one 32-bit value under unit 0's run, gate and source. A 32-bit wrap sets flag1 and leaves flag0 clear.
- R11: A high acknowledge bit clears that unit's flag. A flag set event in the same cycle wins over the acknowledge. A control-byte write loads both flags.
- R12: A bus write to a counter byte in the same cycle as an increment leaves the written value in that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| addr | input | 3 | Byte select for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| cnt_pin | input | 2 | External count pins, bit k for unit k |
| gate_pin | input | 2 | Gate-qualify pins, bit k for unit k |
| ack | input | 2 | Overflow acknowledge, bit k clears flag k |
| ovf | output | 2 | Overflow request flags |

## Verification
The bench builds the block with `TICK_DIV` set to 4 and the default two-stage synchronizer. A 40-cycle window therefore contains exactly ten ticks whatever the prescaler phase, so the internal-source rate and the split high byte can each be checked with one subtraction. The bench preloads bytes next to their terminal values, which puts every wrap path (13-bit, 16-bit, reload, split and 32-bit) only a few count-pin pulses away. The reload path is swept over several reload values. A run of eight back-to-back writes is bound to meet a tick at this divider, so the write-priority rule is exercised on a real collision.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;

    localparam logic [2:0] A_LO0 = 3'd0;
    localparam logic [2:0] A_HI0 = 3'd1;
    localparam logic [2:0] A_LO1 = 3'd2;
    localparam logic [2:0] A_HI1 = 3'd3;
    localparam logic [2:0] A_CFG = 3'd4;
    localparam logic [2:0] A_CTL = 3'd5;

    typedef enum logic [1:0] {
        MD_PRE13   = 2'b00,
        MD_FULL16  = 2'b01,
        MD_RELOAD8 = 2'b10,
        MD_SPLIT   = 2'b11
    } tc_mode_e;

    typedef struct packed {
        logic     gate;
        logic     ext;
        tc_mode_e mode;
    } tc_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              carry;
    } tc_step_t;

    // One increment of a unit in a non-split mode.
    function automatic tc_step_t tc_advance(tc_mode_e m,
                                            logic [BYTE_W-1:0] hi,
                                            logic [BYTE_W-1:0] lo);
        tc_step_t r;
        logic [PRE_W+BYTE_W:0] s13;
        logic [2*BYTE_W:0]     s16;
        r.hi    = hi;
        r.lo    = lo;
        r.carry = 1'b0;
        s13     = '0;
        s16     = '0;
        unique case (m)
            MD_PRE13: begin
                s13 = {1'b0, hi, lo[PRE_W-1:0]} + {{(PRE_W+BYTE_W){1'b0}}, 1'b1};
                r.carry          = s13[PRE_W+BYTE_W];
                r.hi             = s13[PRE_W+BYTE_W-1:PRE_W];
                r.lo[PRE_W-1:0]  = s13[PRE_W-1:0];
            end
            MD_FULL16: begin
                s16 = {1'b0, hi, lo} + {{(2*BYTE_W){1'b0}}, 1'b1};
                r.carry = s16[2*BYTE_W];
                r.hi    = s16[2*BYTE_W-1:BYTE_W];
                r.lo    = s16[BYTE_W-1:0];
            end
            MD_RELOAD8: begin
                if (lo == '1) begin
                    r.lo    = hi;
                    r.carry = 1'b1;
                end else begin
                    r.lo = lo + {{(BYTE_W-1){1'b0}}, 1'b1};
                end
            end
            default: begin
                r.carry = 1'b0;
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tc_tick.sv
module tc_tick #(
    parameter int TICK_DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef enum logic {TICK_WAIT, TICK_FIRE} tick_st_e;

    logic [CW-1:0] cnt_q;
    tick_st_e      st;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (st == TICK_FIRE) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
        end
    end

    always_comb begin
        st = (cnt_q == LAST) ? TICK_FIRE : TICK_WAIT;
    end

    always_comb begin
        unique case (st)
            TICK_FIRE: tick = 1'b1;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tc_sync.sv
module tc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], din};
        end
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/tc_edge.sv
module tc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    typedef enum logic {LV_LOW, LV_HIGH} lvl_e;

    logic lvl;
    lvl_e st_q, st_d;

    tc_sync #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin),
        .dout (lvl)
    );

    always_comb begin
        st_d = lvl ? LV_HIGH : LV_LOW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LV_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q)
            LV_HIGH: fall = (st_d == LV_LOW);
            default: fall = 1'b0;
        endcase
    end
endmodule

// File: rtl/tc_pair.sv
module tc_pair
    import tc_pkg::*;
#(
    parameter int TICK_DIV    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [1:0] cnt_pin,
    input  logic [1:0] gate_pin,
    input  logic [1:0] ack,
    output logic [1:0] ovf
);
    localparam int UNITS = 2;
    localparam int W32   = 4 * BYTE_W;

    logic [BYTE_W-1:0] lo0, hi0, lo1, hi1;
    logic [BYTE_W-1:0] n_lo0, n_hi0, n_lo1, n_hi1;
    logic [7:0]        cfg_q;
    logic [1:0]        run;
    logic              casc;
    logic [1:0]        n_ovf, n_run, set_evt;
    logic              n_casc;
    logic [7:0]        n_cfg;

    logic              tick;
    logic [UNITS-1:0]  fall, gate_lvl, en;
    tc_cfg_t           cfg [UNITS];

    tc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar k = 0; k < UNITS; k++) begin : g_unit
        tc_edge #(.STAGES(SYNC_STAGES)) u_cnt_edge (
            .clk  (clk),
            .rst  (rst),
            .pin  (cnt_pin[k]),
            .fall (fall[k])
        );
        tc_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (gate_pin[k]),
            .dout (gate_lvl[k])
        );
        assign cfg[k] = tc_cfg_t'(cfg_q[4*k +: 4]);
        assign en[k]  = run[k] & (~cfg[k].gate | gate_lvl[k]) &
                        (cfg[k].ext ? fall[k] : tick);
    end

    always_comb begin
        tc_step_t          s0, s1;
        logic [W32:0]      s32;
        logic [BYTE_W:0]   s8;
        n_lo0   = lo0;
        n_hi0   = hi0;
        n_lo1   = lo1;
        n_hi1   = hi1;
        set_evt = 2'b00;
        s0      = tc_advance(cfg[0].mode, hi0, lo0);
        s1      = tc_advance(cfg[1].mode, hi1, lo1);
        s32     = {1'b0, hi1, lo1, hi0, lo0} + {{W32{1'b0}}, 1'b1};
        s8      = '0;
        if (casc) begin
            if (en[0]) begin
                {n_hi1, n_lo1, n_hi0, n_lo0} = s32[W32-1:0];
                set_evt[1] = s32[W32];
            end
        end else begin
            unique case (cfg[0].mode)
                MD_SPLIT: begin
                    if (en[0]) begin
                        s8         = {1'b0, lo0} + {{BYTE_W{1'b0}}, 1'b1};
                        n_lo0      = s8[BYTE_W-1:0];
                        set_evt[0] = s8[BYTE_W];
                    end
                    if (run[1] && tick) begin
                        s8         = {1'b0, hi0} + {{BYTE_W{1'b0}}, 1'b1};
                        n_hi0      = s8[BYTE_W-1:0];
                        set_evt[1] = s8[BYTE_W];
                    end
                end
                default: begin
                    if (en[0]) begin
                        n_hi0      = s0.hi;
                        n_lo0      = s0.lo;
                        set_evt[0] = s0.carry;
                    end
                end
            endcase
            unique case (cfg[1].mode)
                MD_SPLIT: begin
                    n_hi1 = hi1;
                    n_lo1 = lo1;
                end
                default: begin
                    if (en[1]) begin
                        n_hi1 = s1.hi;
                        n_lo1 = s1.lo;
                        if (s1.carry) set_evt[1] = 1'b1;
                    end
                end
            endcase
        end

        for (int k = 0; k < UNITS; k++) begin
            n_ovf[k] = set_evt[k] ? 1'b1 : (ack[k] ? 1'b0 : ovf[k]);
        end
        n_run  = run;
        n_casc = casc;
        n_cfg  = cfg_q;

        if (wr_en) begin
            unique case (addr)
                A_LO0: n_lo0 = wdata;
                A_HI0: n_hi0 = wdata;
                A_LO1: n_lo1 = wdata;
                A_HI1: n_hi1 = wdata;
                A_CFG: n_cfg = wdata;
                A_CTL: begin
                    n_run  = wdata[1:0];
                    n_ovf  = wdata[3:2];
                    n_casc = wdata[4];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo0   <= '0;
            hi0   <= '0;
            lo1   <= '0;
            hi1   <= '0;
            cfg_q <= '0;
            run   <= '0;
            casc  <= 1'b0;
            ovf   <= '0;
        end else begin
            lo0   <= n_lo0;
            hi0   <= n_hi0;
            lo1   <= n_lo1;
            hi1   <= n_hi1;
            cfg_q <= n_cfg;
            run   <= n_run;
            casc  <= n_casc;
            ovf   <= n_ovf;
        end
    end

    always_comb begin
        unique case (addr)
            A_LO0:   rdata = lo0;
            A_HI0:   rdata = hi0;
            A_LO1:   rdata = lo1;
            A_HI1:   rdata = hi1;
            A_CFG:   rdata = cfg_q;
            A_CTL:   rdata = {3'b000, casc, ovf, run};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/tc_pair_chk.sv
module tc_pair_chk
    import tc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [1:0] ack,
    input logic [1:0] ovf,
    input logic [1:0] set_evt,
    input logic [1:0] run,
    input logic       casc,
    input logic [7:0] cfg_q,
    input logic [7:0] lo0,
    input logic [7:0] hi0,
    input logic [7:0] lo1,
    input logic [7:0] hi1
);
    logic ctl_wr;
    assign ctl_wr = wr_en && (addr == A_CTL);

    // R1: reset leaves no request pending
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (ovf == 2'b00));

    // R3: a carry event raises the flag
    p_set_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (set_evt[0] && !ctl_wr) |=> ovf[0]);

    // R11: acknowledge without a new event clears the flag
    p_ack_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (ack[1] && !set_evt[1] && !ctl_wr) |=> !ovf[1]);

    // R11: a flag only rises from an event or a control write
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf[0]) |-> $past(set_evt[0] || ctl_wr));

    // R7: unit 1 in mode 11 holds
    p_halt_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[5:4] == 2'b11 && !casc &&
         !(wr_en && (addr == A_LO1 || addr == A_HI1)))
        |=> $stable({hi1, lo1}));

    // R8: nothing counts while both run bits are clear
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (run == 2'b00 && !wr_en) |=> $stable({hi1, lo1, hi0, lo0}));
endmodule

bind tc_pair tc_pair_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .ack     (ack),
    .ovf     (ovf),
    .set_evt (set_evt),
    .run     (run),
    .casc    (casc),
    .cfg_q   (cfg_q),
    .lo0     (lo0),
    .hi0     (hi0),
    .lo1     (lo1),
    .hi1     (hi1)
);

// File: tb/tc_pair_test.sv
module tc_pair_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] cnt_pin = 2'b00;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] ack = 2'b00;
    logic [1:0] ovf;

    int n_chk = 0;
    int n_fail = 0;

    tc_pair #(.TICK_DIV(DIV), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .ack(ack), .ovf(ovf)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        cnt_pin[k] = 1'b1;
        repeat (4) @(negedge clk);
        cnt_pin[k] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic do_ack(input int k);
        @(negedge clk);
        ack[k] = 1'b1;
        @(negedge clk);
        ack[k] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v, a0, b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every byte and the outputs
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), v);
            check("R1 reset byte", v, 8'h00);
        end
        check("R1 ovf after reset", {6'd0, ovf}, 8'h00);

        // R2: map readback and the unused control bits
        wr(3'd4, 8'hA5);
        rd(3'd4, v); check("R2 mode byte readback", v, 8'hA5);
        wr(3'd5, 8'hEC);
        rd(3'd5, v); check("R2 control readback", v, 8'h0C);
        check("R11 flags loaded by write", {6'd0, ovf}, 8'h03);
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h00);

        // R3: 16-bit mode via external pin (mode byte unit0 = 0101)
        wr(3'd4, 8'h05);
        wr(3'd1, 8'hFF); wr(3'd0, 8'hFD);
        wr(3'd5, 8'h01);
        pulse(0); pulse(0);
        rd(3'd0, v); check("R3 lo after 2", v, 8'hFF);
        check("R3 no flag yet", {7'd0, ovf[0]}, 8'h00);
        pulse(0);
        rd(3'd0, v); check("R3 lo wrap", v, 8'h00);
        rd(3'd1, v); check("R3 hi wrap", v, 8'h00);
        check("R3 flag set", {7'd0, ovf[0]}, 8'h01);

        // R11: acknowledge clears
        do_ack(0);
        check("R11 ack clears", {7'd0, ovf[0]}, 8'h00);

        // R8: gate holds counting until pin high (unit0 = 1101)
        wr(3'd4, 8'h0D);
        wr(3'd0, 8'h10);
        pulse(0); pulse(0);
        rd(3'd0, v); check("R8 gated off", v, 8'h10);
        gate_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        pulse(0); pulse(0);
        rd(3'd0, v); check("R8 gated on", v, 8'h12);
        gate_pin[0] = 1'b0;

        // R8: run bit off stops counting
        wr(3'd4, 8'h05);
        wr(3'd5, 8'h00);
        pulse(0);
        rd(3'd0, v); check("R8 run off", v, 8'h12);

        // R4: 13-bit mode (unit0 = 0100)
        wr(3'd4, 8'h04);
        wr(3'd1, 8'hFF); wr(3'd0, 8'hFE);
        wr(3'd5, 8'h01);
        pulse(0);
        rd(3'd0, v); check("R4 lo step", v, 8'hFF);
        check("R4 no flag", {7'd0, ovf[0]}, 8'h00);
        pulse(0);
        rd(3'd0, v); check("R4 lo keeps upper bits", v, 8'hE0);
        rd(3'd1, v); check("R4 hi wrap", v, 8'h00);
        check("R4 flag", {7'd0, ovf[0]}, 8'h01);
        do_ack(0);

        // R5: reload sweep (unit0 = 0110)
        wr(3'd4, 8'h06);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] r;
            r = 8'(i * 8'h55);
            wr(3'd1, r); wr(3'd0, 8'hFE);
            pulse(0);
            rd(3'd0, v); check("R5 pre-reload", v, 8'hFF);
            pulse(0);
            rd(3'd0, v); check("R5 reloaded lo", v, r);
            rd(3'd1, v); check("R5 hi unchanged", v, r);
            check("R5 flag", {7'd0, ovf[0]}, 8'h01);
            do_ack(0);
        end

        // R12: writes collide with ticks (unit0 internal, 16-bit)
        wr(3'd4, 8'h01);
        wr(3'd1, 8'h00);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i > 0) check("R12 write wins", rdata, 8'h40);
            addr = 3'd0; wdata = 8'h40; wr_en = 1'b1;
        end
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R12 write wins last", rdata, 8'h40);
        wr(3'd5, 8'h00);

        // R9: internal rate on unit1 (unit1 = 0001)
        wr(3'd4, 8'h10);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd5, 8'h02);
        @(negedge clk); addr = 3'd2; #1 a0 = rdata;
        repeat (40) @(negedge clk);
        #1 b0 = rdata;
        check("R9 ten ticks per 40 cycles", b0 - a0, 8'd10);
        wr(3'd5, 8'h00);

        // R6: split low byte on pin, high byte on run1 ticks
        wr(3'd4, 8'h77);                  // unit0 ext split, unit1 ext mode3
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFA);
        wr(3'd5, 8'h01);
        pulse(0);
        rd(3'd0, v); check("R6 split lo wrap", v, 8'h00);
        rd(3'd1, v); check("R6 hi idle without run1", v, 8'hFA);
        check("R6 flag0 from lo", {6'd0, ovf}, 8'h01);
        wr(3'd5, 8'h02);
        @(negedge clk); addr = 3'd1; #1 a0 = rdata;
        repeat (40) @(negedge clk);
        #1 b0 = rdata;
        check("R6 hi counts ticks", b0 - a0, 8'd10);
        check("R6 flag1 from hi", {6'd0, ovf}, 8'h02);
        wr(3'd5, 8'h00);

        // R7: unit1 mode 3 frozen, then counts in mode 1
        wr(3'd4, 8'h70);
        wr(3'd2, 8'h12); wr(3'd3, 8'h34);
        wr(3'd5, 8'h02);
        pulse(1); pulse(1); pulse(1);
        rd(3'd2, v); check("R7 lo held", v, 8'h12);
        rd(3'd3, v); check("R7 hi held", v, 8'h34);
        wr(3'd4, 8'h50);
        pulse(1);
        rd(3'd2, v); check("R9 ext edge counts unit1", v, 8'h13);
        wr(3'd5, 8'h00);

        // R10: cascade 32-bit
        wr(3'd4, 8'h04);
        wr(3'd0, 8'hFE); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd5, 8'h11);
        pulse(0);
        rd(3'd0, v); check("R10 step", v, 8'hFF);
        check("R10 no flag", {6'd0, ovf}, 8'h00);
        pulse(0);
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), v);
            check("R10 wrap byte", v, 8'h00);
        end
        check("R10 flag1 only", {6'd0, ovf}, 8'h02);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule